// File: doc/BRIEF.md
# Programmable Mux-Divider Frequency Generator Bank

The block holds six frequency generators whose settings live in two 32-bit control words, three generators to a word. Every generator selects one of several PLL sources, divides that source by a programmable integer and can be switched off. Software writes and reads the control words through a simple register port. Each generator drives one output.

To keep the whole bank in one synchronous clock domain, each PLL source arrives as a single-cycle clock-enable strobe. Each generator produces a one-cycle output strobe once per divided period. It also drives a square wave that flips on every output strobe. An elaboration-time parameter picks one of two field layouts. In the legacy layout a generator has a one-bit source choice and its own enable bit, and divides only by even amounts. In the extended layout a two-bit source code uses zero to mean off, and a per-word scale bit allows any integer division.

A new divider or source value is taken up only when the current output period ends, so no shortened period is ever produced. Switching a generator off takes effect at once. The output stays low and the counter restarts from zero when the generator is enabled again.

Top module: `fgen_bank`

## Requirements
- R1: After reset both control words read as zero and every output strobe and square wave is low.
- R2: A read of a control word returns the last value written to it, all 32 bits, including bits no generator uses.
- R3: Generator g takes its 10-bit field from control word g/3, starting at bit 10*(g mod 3). In the strobe vector, bit 0 is the CPU PLL, bit 1 the AUX PLL and bit 2 the AUX PLL2.
- R4: Legacy layout: field bit 0 picks the source (0 = CPU PLL, 1 = AUX PLL) and field bit 1 enables the generator (1 = on). Strobes from the source that is not selected are not counted.
- R5: Legacy layout: field bits 9:2 hold d, and one output strobe is issued for every (d+1)*2 selected source strobes, giving 2 to 512.
- R6: Extended layout: field bits 1:0 select the source (0 = off, 1 = AUX PLL2, 2 = CPU PLL, 3 = AUX PLL). There is no separate enable bit.
- R7: Extended layout: bit 30 of a control word is the scale bit for its three generators. When it is set the division is d+1 (1 to 256). When it is clear the division is (d+1)*2.
- R8: The output strobe is high for the one cycle after the clock edge that takes in the N-th selected source strobe of a period. The square wave flips at that same edge.
- R9: A change of divider or source written while a generator runs takes effect only after the current period has completed.
- R10: While a generator is off, its output strobe and square wave are low and its counter is held at zero. After re-enabling, the first output strobe comes after a full N source strobes.
- R11: Legacy layout: bit 30 of a control word has no effect on division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for a control word |
| wr_sel | input | 1 | Control word index for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Control word index for reads |
| rd_data | output | 32 | Read data of the selected control word |
| pll_stb | input | 3 | Source strobes: bit 0 CPU PLL, bit 1 AUX PLL, bit 2 AUX PLL2 |
| gen_tick | output | 6 | One-cycle output strobe per generator |
| gen_wave | output | 6 | Square wave per generator, flips on each output strobe |

## Verification
The bench builds two copies of the bank side by side: one with the legacy layout (EXTENDED = 0) and one with the extended layout (EXTENDED = 1), both with six generators in two words. The legacy copy covers the even-only divider up to its 512 limit, the separate enable bit and the inert bit 30. The extended copy covers all four source codes, including the zero code as off, and both settings of the scale bit, down to division by one. A rewrite in mid-period shows whether the old period finishes before the new setting applies.

// File: rtl/fgen_pkg.sv
// Shared constants and types for the frequency generator bank.
// Assumes the field layout fixed by the control word format: 10 bits per generator.
package fgen_pkg;
    localparam int FIELD_W  = 10;  // bits per generator field
    localparam int DIV_W    = 8;   // divider value width inside a field
    localparam int NUM_SRC  = 3;   // number of PLL strobe sources
    localparam int SRC_CPU  = 0;   // strobe bit of the CPU PLL
    localparam int SRC_AUX  = 1;   // strobe bit of the AUX PLL
    localparam int SRC_AUX2 = 2;   // strobe bit of the AUX PLL2
    typedef logic [NUM_SRC-1:0] src_mask_t;
endpackage

// File: rtl/fgen_regs.sv
// Control word storage for the generator bank.
// Holds NUM_REG words written whole; reads return stored bits unchanged.
module fgen_regs #(
    parameter int NUM_REG = 2,
    parameter int REG_W   = 32,
    parameter int SEL_W   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [REG_W-1:0]         rd_data,
    output logic [NUM_REG*REG_W-1:0] regs_flat
);
    logic [NUM_REG-1:0][REG_W-1:0] regs_q;

    // Store a whole word on each write; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en && (int'(wr_sel) < NUM_REG)) begin
            regs_q[wr_sel] <= wr_data;
        end
    end

    // Read path and flat view for the decoders.
    always_comb begin
        rd_data   = (int'(rd_sel) < NUM_REG) ? regs_q[rd_sel] : '0;
        regs_flat = regs_q;
    end

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/fgen_decode.sv
// Decodes one generator field into enable, one-hot source and division count.
// EXTENDED picks the field layout at elaboration; division is never zero.
module fgen_decode
    import fgen_pkg::*;
#(
    parameter bit EXTENDED = 1'b0,
    parameter int CNT_W    = DIV_W + 2
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               scale_i,
    output logic               en_o,
    output src_mask_t          src_o,
    output logic [CNT_W-1:0]   n_o
);
    logic [CNT_W-1:0] base;

    // Divider value plus one, the odd/any-integer base.
    always_comb base = CNT_W'(field_i[FIELD_W-1:2]) + CNT_W'(1);

    generate
        if (EXTENDED) begin : g_ext
            // Two-bit source code with zero as off; scale bit picks x1 or x2.
            always_comb begin
                en_o  = 1'b1;
                src_o = '0;
                unique case (field_i[1:0])
                    2'd0: en_o  = 1'b0;
                    2'd1: src_o = src_mask_t'(1) << SRC_AUX2;
                    2'd2: src_o = src_mask_t'(1) << SRC_CPU;
                    default: src_o = src_mask_t'(1) << SRC_AUX;
                endcase
                n_o = scale_i ? base : (base << 1);
            end
        end else begin : g_legacy
            logic unused_scale;
            assign unused_scale = scale_i;
            // One-bit source, separate enable, even division only.
            always_comb begin
                en_o  = field_i[1];
                src_o = field_i[0] ? (src_mask_t'(1) << SRC_AUX)
                                   : (src_mask_t'(1) << SRC_CPU);
                n_o   = base << 1;
            end
        end
    endgenerate
endmodule

// File: rtl/fgen_channel.sv
// One divider channel: counts selected source strobes and emits a strobe
// and a toggling wave every n strobes. New settings load at period end;
// a low cfg_en stops it at once and holds the count at zero.
module fgen_channel #(
    parameter int NUM_SRC = 3,
    parameter int CNT_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pll_stb,
    input  logic               cfg_en,
    input  logic [NUM_SRC-1:0] cfg_src,
    input  logic [CNT_W-1:0]   cfg_n,
    output logic               tick_o,
    output logic               wave_o
);
    logic               run_q;
    logic [NUM_SRC-1:0] src_q;
    logic [CNT_W-1:0]   n_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               tick_q;
    logic               wave_q;
    logic               stb;

    // Strobe from the currently latched source.
    always_comb stb = |(pll_stb & src_q);

    // Period counter with boundary-latched configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            src_q  <= '0;
            n_q    <= CNT_W'(1);
            cnt_q  <= '0;
            tick_q <= 1'b0;
            wave_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (!cfg_en) begin
                run_q  <= 1'b0;
                cnt_q  <= '0;
                wave_q <= 1'b0;
                src_q  <= cfg_src;
                n_q    <= cfg_n;
            end else if (!run_q) begin
                run_q <= 1'b1;
                cnt_q <= '0;
                src_q <= cfg_src;
                n_q   <= cfg_n;
            end else if (stb) begin
                if (cnt_q == n_q - CNT_W'(1)) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                    wave_q <= ~wave_q;
                    src_q  <= cfg_src;
                    n_q    <= cfg_n;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign tick_o = tick_q;
    assign wave_o = wave_q;

    // R10
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!wave_q && !tick_q && cnt_q == '0));
    // R8
    tick_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> $past(run_q && stb));
    // R8
    wave_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> wave_q != $past(wave_q));
    // R9
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < n_q);
endmodule

// File: rtl/fgen_bank.sv
// Bank of mux-divider frequency generators sharing a control register port.
// Generator g uses word g/GEN_PER_REG at offset FIELD_W*(g mod GEN_PER_REG);
// SCALE_BIT of each word applies to its generators in extended layout.
module fgen_bank
    import fgen_pkg::*;
#(
    parameter int NUM_GEN     = 6,
    parameter int GEN_PER_REG = 3,
    parameter int REG_W       = 32,
    parameter int SCALE_BIT   = 30,
    parameter bit EXTENDED    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [0:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [0:0]         rd_sel,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] pll_stb,
    output logic [NUM_GEN-1:0] gen_tick,
    output logic [NUM_GEN-1:0] gen_wave
);
    localparam int NUM_REG = (NUM_GEN + GEN_PER_REG - 1) / GEN_PER_REG;
    localparam int CNT_W   = DIV_W + 2;

    logic [NUM_REG*REG_W-1:0] regs_flat;
    logic                     unused_bits;

    assign unused_bits = ^regs_flat;

    fgen_regs #(
        .NUM_REG (NUM_REG),
        .REG_W   (REG_W),
        .SEL_W   (1)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
            localparam int RIDX = g / GEN_PER_REG;
            localparam int OFF  = FIELD_W * (g % GEN_PER_REG);

            logic             en;
            src_mask_t        src;
            logic [CNT_W-1:0] n;

            fgen_decode #(
                .EXTENDED (EXTENDED),
                .CNT_W    (CNT_W)
            ) u_dec (
                .field_i (regs_flat[RIDX*REG_W + OFF +: FIELD_W]),
                .scale_i (regs_flat[RIDX*REG_W + SCALE_BIT]),
                .en_o    (en),
                .src_o   (src),
                .n_o     (n)
            );

            fgen_channel #(
                .NUM_SRC (NUM_SRC),
                .CNT_W   (CNT_W)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .pll_stb (pll_stb),
                .cfg_en  (en),
                .cfg_src (src),
                .cfg_n   (n),
                .tick_o  (gen_tick[g]),
                .wave_o  (gen_wave[g])
            );
        end
    endgenerate
endmodule

// File: tb/test_fgen_bank.sv
`timescale 1ns/1ps
// Directed bench: a legacy-layout and an extended-layout bank side by side.
module test_fgen_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_l = 1'b0, wr_en_e = 1'b0;
    logic [0:0]  wr_sel = '0, rd_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_l, rd_e;
    logic [2:0]  pll_stb = '0;
    logic [5:0]  tick_l, wave_l, tick_e, wave_e;

    int checks = 0, fails = 0;
    int cnt_l[6], cnt_e[6];
    bit done = 1'b0;

    localparam logic [2:0] CPU = 3'b001, AUX = 3'b010, AUX2 = 3'b100;

    always #10 clk = ~clk;

    fgen_bank #(.EXTENDED(1'b0)) i_fgen_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_l), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_l),
        .pll_stb(pll_stb), .gen_tick(tick_l), .gen_wave(wave_l));

    fgen_bank #(.EXTENDED(1'b1)) i_fgen_bank_ext (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_e), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_e),
        .pll_stb(pll_stb), .gen_tick(tick_e), .gen_wave(wave_e));

    // Free-running output strobe counters, sampled away from the edge.
    initial for (int g = 0; g < 6; g++) begin cnt_l[g] = 0; cnt_e[g] = 0; end
    always @(negedge clk) begin
        for (int g = 0; g < 6; g++) begin
            if (tick_l[g] === 1'b1) cnt_l[g]++;
            if (tick_e[g] === 1'b1) cnt_e[g]++;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] lf(int d, bit en, bit src);
        return {d[7:0], en, src};
    endfunction

    function automatic logic [9:0] ef(int d, int src);
        return {d[7:0], src[1:0]};
    endfunction

    task automatic wr(bit ext, int sel, logic [31:0] data);
        @(negedge clk);
        wr_sel  = sel[0:0];
        wr_data = data;
        if (ext) wr_en_e = 1'b1; else wr_en_l = 1'b1;
        @(negedge clk);
        wr_en_l = 1'b0;
        wr_en_e = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic strobe(logic [2:0] mask, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pll_stb = mask;
            @(negedge clk) pll_stb = '0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd_sel = 1'b0; #1;
        chk("R1 legacy word0", int'(rd_l), 0);
        chk("R1 extended word0", int'(rd_e), 0);
        rd_sel = 1'b1; #1;
        chk("R1 legacy word1", int'(rd_l), 0);
        chk("R1 outputs", int'({tick_l, wave_l, tick_e, wave_e}), 0);
    endtask

    task automatic t_readback;
        wr(0, 1, 32'hC5A3_96E1);
        rd_sel = 1'b1; #1;
        chk("R2 readback", int'(rd_l), int'(32'hC5A3_96E1));
        wr(1, 0, 32'h7F00_13FF);
        rd_sel = 1'b0; #1;
        chk("R2 readback ext", int'(rd_e), int'(32'h7F00_13FF));
        wr(0, 1, 0);
        wr(1, 0, 0);
    endtask

    task automatic t_legacy_div;
        int b;
        wr(0, 0, {22'd0, lf(2, 1, 0)});
        b = cnt_l[0];
        strobe(CPU, 30);
        chk("R5 d=2 divide by 6", cnt_l[0] - b, 5);
        chk("R8 wave after odd ticks", int'(wave_l[0]), 1);
        wr(0, 0, 0);
        wr(0, 0, {22'd0, lf(0, 1, 0)});
        b = cnt_l[0];
        strobe(CPU, 7);
        chk("R5 d=0 divide by 2", cnt_l[0] - b, 3);
        wr(0, 0, 0);
    endtask

    task automatic t_legacy_max;
        int b;
        wr(0, 0, {22'd0, lf(255, 1, 0)});
        b = cnt_l[0];
        strobe(CPU, 511);
        chk("R5 d=255 before 512th", cnt_l[0] - b, 0);
        strobe(CPU, 1);
        chk("R5 d=255 at 512th", cnt_l[0] - b, 1);
        wr(0, 0, 0);
    endtask

    task automatic t_legacy_src;
        int b;
        wr(0, 0, {22'd0, lf(0, 1, 1)});
        b = cnt_l[0];
        strobe(CPU, 8);
        chk("R4 unselected CPU ignored", cnt_l[0] - b, 0);
        strobe(AUX, 8);
        chk("R4 AUX selected", cnt_l[0] - b, 4);
        wr(0, 0, 0);
        wr(0, 0, {22'd0, lf(0, 0, 0)});
        b = cnt_l[0];
        strobe(CPU, 6);
        chk("R4 enable bit clear", cnt_l[0] - b, 0);
        wr(0, 0, 0);
    endtask

    task automatic t_field_pos;
        int b0, b4, b5;
        wr(0, 1, {12'd0, lf(1, 1, 0), 10'd0});
        b0 = cnt_l[3]; b4 = cnt_l[4]; b5 = cnt_l[5];
        strobe(CPU, 8);
        chk("R3 generator 4 at word1 bit10", cnt_l[4] - b4, 2);
        chk("R3 generator 3 idle", cnt_l[3] - b0, 0);
        chk("R3 generator 5 idle", cnt_l[5] - b5, 0);
        wr(0, 1, 0);
    endtask

    task automatic t_boundary;
        int b;
        wr(0, 0, {22'd0, lf(1, 1, 0)});
        b = cnt_l[0];
        strobe(CPU, 2);
        wr(0, 0, {22'd0, lf(0, 1, 0)});
        strobe(CPU, 2);
        chk("R9 old period completes", cnt_l[0] - b, 1);
        strobe(CPU, 4);
        chk("R9 new divider after boundary", cnt_l[0] - b, 3);
        wr(0, 0, 0);
    endtask

    task automatic t_disable;
        int b;
        wr(0, 0, {22'd0, lf(1, 1, 0)});
        strobe(CPU, 4);
        chk("R8 wave high after one tick", int'(wave_l[0]), 1);
        wr(0, 0, {22'd0, lf(1, 0, 0)});
        chk("R10 wave low when off", int'(wave_l[0]), 0);
        b = cnt_l[0];
        strobe(CPU, 3);
        chk("R10 no strobes when off", cnt_l[0] - b, 0);
        wr(0, 0, {22'd0, lf(1, 1, 0)});
        strobe(CPU, 3);
        chk("R10 counter restarted", cnt_l[0] - b, 0);
        strobe(CPU, 1);
        chk("R10 full period after re-enable", cnt_l[0] - b, 1);
        wr(0, 0, 0);
    endtask

    task automatic t_scale_ignored;
        int b;
        wr(0, 0, 32'h4000_0000 | {22'd0, lf(0, 1, 0)});
        b = cnt_l[0];
        strobe(CPU, 6);
        chk("R11 bit30 ignored in legacy", cnt_l[0] - b, 3);
        wr(0, 0, 0);
    endtask

    task automatic t_ext_src;
        int b;
        wr(1, 0, {22'd0, ef(0, 1)});
        b = cnt_e[0];
        strobe(CPU, 4);
        chk("R6 code1 ignores CPU", cnt_e[0] - b, 0);
        strobe(AUX2, 4);
        chk("R6 code1 AUX2", cnt_e[0] - b, 2);
        wr(1, 0, 0);
        wr(1, 0, {22'd0, ef(0, 2)});
        b = cnt_e[0];
        strobe(CPU, 4);
        chk("R6 code2 CPU", cnt_e[0] - b, 2);
        wr(1, 0, 0);
        wr(1, 0, {22'd0, ef(0, 3)});
        b = cnt_e[0];
        strobe(AUX, 4);
        chk("R6 code3 AUX", cnt_e[0] - b, 2);
        wr(1, 0, {22'd0, ef(0, 0)});
        b = cnt_e[0];
        strobe(3'b111, 4);
        chk("R6 code0 off", cnt_e[0] - b, 0);
        chk("R6 code0 wave low", int'(wave_e[0]), 0);
    endtask

    task automatic t_ext_scale;
        int b;
        wr(1, 0, 32'h4000_0000 | {22'd0, ef(0, 2)});
        b = cnt_e[0];
        strobe(CPU, 5);
        chk("R7 scale set divide by 1", cnt_e[0] - b, 5);
        chk("R7 wave after five ticks", int'(wave_e[0]), 1);
        wr(1, 0, 32'h4000_0000);
        wr(1, 0, 32'h4000_0000 | {22'd0, ef(2, 2)});
        b = cnt_e[0];
        strobe(CPU, 9);
        chk("R7 scale set divide by 3", cnt_e[0] - b, 3);
        wr(1, 0, 0);
        wr(1, 0, {22'd0, ef(2, 2)});
        b = cnt_e[0];
        strobe(CPU, 12);
        chk("R7 scale clear divide by 6", cnt_e[0] - b, 2);
        wr(1, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_readback;
        t_legacy_div;
        t_legacy_max;
        t_legacy_src;
        t_field_pos;
        t_boundary;
        t_disable;
        t_scale_ignored;
        t_ext_src;
        t_ext_scale;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule